// File: doc/BRIEF.md
# Hot-Swap Fault Supervisor

This block is the digital decision logic beside a high-side power switch. It receives sampled load-current and bus-voltage codes together with an enable input and a power-good flag from an undervoltage detector. It decides whether the switch gate may be on. Three protection tiers run side by side. An over-power check multiplies voltage by current and compares the product with a limit. An over-current check compares current with a programmable limit. A hard-short check compares current with a fixed high limit. The first two must persist for a programmable number of cycles before they trip. The third trips on the first sample.

Any trip latches an active-low fault flag, turns the gate off and records a root-cause code. The fault latch clears when enable is driven low, and monitoring starts again when enable returns high. A separate switch-failure detector watches for current that keeps flowing while the gate is commanded off. It drives its own active-low flag, which only a loss of power-good clears. A current-only mode removes the over-power path and leaves every other check running.

All thresholds, delay codes and the mode bit are taken in only while enable is low. A setting changed while enable is high therefore cannot disturb a trip decision that is in progress.

Top module: `hsw_supervisor`

## Requirements
- R1: `gate_on_o` rises at the first clock edge at which `en_i` and `pwr_ok_i` are both high and no fault is latched. It falls at the first edge at which either input is low.
- R2: When `i_code_i * v_code_i` is strictly greater than the power limit on every sampled cycle, the fault is raised after the effective power delay T. With the input applied before edge 0, `fault_n_o` goes low and `gate_on_o` goes low at edge T+1, and `cause_o` reads 1. A product equal to the limit never trips.
- R3: If a qualifying condition is absent for one sampled cycle before its timer expires, that timer restarts from zero, and the next trip needs a full T cycles again.
- R4: When `i_code_i` is strictly greater than the current limit for the effective current delay, the fault latches with `cause_o` = 2 (edge T+1 as in R2). A current equal to the limit never trips. When both timers expire on the same edge, the code is 2.
- R5: When `i_code_i` is greater than `SC_LIM`, the fault latches and the gate falls at edge 1 after the sample, with `cause_o` = 3. No delay timer is involved.
- R6: A delay code of zero selects the fixed minimum delay `MIN_DLY`.
- R7: A latched fault keeps `fault_n_o` low, the gate off and `cause_o` unchanged while enable stays high, even after the condition is gone. At the first edge with `en_i` low, `fault_n_o` returns high and `cause_o` returns to 0 (0 means no fault).
- R8: When the gate is off and `i_code_i` is greater than `LEAK_LIM` for `LEAK_CYC` consecutive sampled cycles, `swfail_n_o` goes low at edge `LEAK_CYC`+1. `fault_n_o` is not changed by this.
- R9: Once `swfail_n_o` is low, it stays low through any toggling of `en_i`. It returns high only at an edge where `pwr_ok_i` is low.
- R10: When the current-only mode bit is captured as 1, the power path never trips. The over-current, hard-short and switch-failure checks still work.
- R11: The limits, delay codes and mode bit are captured only on edges where `en_i` is low. Changes made while enabled have no effect until enable next goes low.
- R12: After synchronous reset, `gate_on_o` = 0, `fault_n_o` = 1, `swfail_n_o` = 1 and `cause_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable; a low level clears the fault latch |
| pwr_ok_i | input | 1 | Supply above the undervoltage limit; a low level acts as a power cycle |
| cur_only_i | input | 1 | 1 disables the power path |
| i_code_i | input | IW | Sampled load-current code |
| v_code_i | input | VW | Sampled bus-voltage code |
| pwr_lim_i | input | IW+VW | Power limit, in code units of current times voltage |
| oc_lim_i | input | IW | Over-current limit |
| dly_pwr_i | input | TW | Power qualification delay in cycles (0 selects the minimum) |
| dly_oc_i | input | TW | Current qualification delay in cycles (0 selects the minimum) |
| gate_on_o | output | 1 | Gate enable to the switch driver |
| fault_n_o | output | 1 | Latched fault flag, active low |
| swfail_n_o | output | 1 | Switch-failure flag, active low |
| cause_o | output | 2 | Root cause: 0 none, 1 power, 2 current, 3 hard short |

## Verification
Counted from the edge that first samples a changed current or voltage, a hard short appears at the next edge. A timed trip appears T+1 edges later, and a switch failure appears `LEAK_CYC`+1 edges later. Changes to enable and power-good act at the first edge. Every stimulus pushes its expected output values into a scoreboard, tagged with the exact cycle in which they are due. The monitor compares them at the falling edge of that cycle. For each timed trip, the bench also checks the cycle just before, so a trip that comes one cycle early or one cycle late is reported.

// File: rtl/hsw_pkg.sv
`timescale 1ns/1ps
package hsw_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_PWR   = 2'd1,
    CAUSE_OC    = 2'd2,
    CAUSE_SHORT = 2'd3
  } cause_e;

  localparam int TMR_PWR  = 0;
  localparam int TMR_OC   = 1;
  localparam int TMR_LEAK = 2;
  localparam int NUM_TMR  = 3;
endpackage

// File: rtl/hsw_cfg_capture.sv
`timescale 1ns/1ps
// Holds the settings; they load only while the supervisor is disabled.
module hsw_cfg_capture #(
  parameter int IW      = 10,
  parameter int PW      = 20,
  parameter int TW      = 16,
  parameter int MIN_DLY = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          cur_only_i,
  input  logic [PW-1:0] pwr_lim_i,
  input  logic [IW-1:0] oc_lim_i,
  input  logic [TW-1:0] dly_pwr_i,
  input  logic [TW-1:0] dly_oc_i,
  output logic          cur_only_q,
  output logic [PW-1:0] pwr_lim_q,
  output logic [IW-1:0] oc_lim_q,
  output logic [TW-1:0] term_pwr_q,
  output logic [TW-1:0] term_oc_q
);
  localparam logic [TW-1:0] MIN_TERM = TW'(MIN_DLY);

  function automatic logic [TW-1:0] eff_term(input logic [TW-1:0] code);
    return (code == '0) ? MIN_TERM : code;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_only_q <= 1'b0;
      pwr_lim_q  <= '1;
      oc_lim_q   <= '1;
      term_pwr_q <= MIN_TERM;
      term_oc_q  <= MIN_TERM;
    end else if (!en_i) begin
      cur_only_q <= cur_only_i;
      pwr_lim_q  <= pwr_lim_i;
      oc_lim_q   <= oc_lim_i;
      term_pwr_q <= eff_term(dly_pwr_i);
      term_oc_q  <= eff_term(dly_oc_i);
    end
  end
endmodule

// File: rtl/hsw_qual_timer.sv
`timescale 1ns/1ps
// Consecutive-cycle qualifier: counts while cond holds, clears on any gap.
module hsw_qual_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          cond,
  input  logic [TW-1:0] term,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || !cond) begin
      cnt <= '0;
    end else if (cnt != term) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (term != '0) && (cnt == term);
endmodule

// File: rtl/hsw_fault_core.sv
`timescale 1ns/1ps
// Fault latch, cause register, gate register and switch-failure latch.
module hsw_fault_core
  import hsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       pwr_ok_i,
  input  logic       short_hit,
  input  logic       pwr_exp,
  input  logic       oc_exp,
  input  logic       leak_exp,
  output logic       arm,
  output logic       gate_q,
  output logic       fault_q,
  output logic       sw_q,
  output logic [1:0] cause_q
);
  cause_e cause_r;
  cause_e cause_nx;
  logic   trip;

  assign arm  = en_i && pwr_ok_i;
  assign trip = arm && !fault_q && (short_hit || pwr_exp || oc_exp);

  always_comb begin
    if (oc_exp)       cause_nx = CAUSE_OC;
    else if (pwr_exp) cause_nx = CAUSE_PWR;
    else              cause_nx = CAUSE_SHORT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
      cause_r <= CAUSE_NONE;
      gate_q  <= 1'b0;
      sw_q    <= 1'b0;
    end else begin
      if (!arm) begin
        fault_q <= 1'b0;
        cause_r <= CAUSE_NONE;
      end else if (trip) begin
        fault_q <= 1'b1;
        cause_r <= cause_nx;
      end
      gate_q <= arm && !fault_q && !trip;
      if (!pwr_ok_i)     sw_q <= 1'b0;
      else if (leak_exp) sw_q <= 1'b1;
    end
  end

  assign cause_q = cause_r;
endmodule

// File: rtl/hsw_supervisor.sv
`timescale 1ns/1ps
module hsw_supervisor
  import hsw_pkg::*;
#(
  parameter int IW       = 10,
  parameter int VW       = 10,
  parameter int TW       = 16,
  parameter int SC_LIM   = 900,
  parameter int LEAK_LIM = 20,
  parameter int LEAK_CYC = 4,
  parameter int MIN_DLY  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic                 pwr_ok_i,
  input  logic                 cur_only_i,
  input  logic [IW-1:0]        i_code_i,
  input  logic [VW-1:0]        v_code_i,
  input  logic [IW+VW-1:0]     pwr_lim_i,
  input  logic [IW-1:0]        oc_lim_i,
  input  logic [TW-1:0]        dly_pwr_i,
  input  logic [TW-1:0]        dly_oc_i,
  output logic                 gate_on_o,
  output logic                 fault_n_o,
  output logic                 swfail_n_o,
  output logic [1:0]           cause_o
);
  localparam int PW = IW + VW;
  localparam logic [IW-1:0] SC_CODE   = IW'(SC_LIM);
  localparam logic [IW-1:0] LEAK_CODE = IW'(LEAK_LIM);
  localparam logic [TW-1:0] LEAK_TERM = TW'(LEAK_CYC);

  logic [IW-1:0] i_q;
  logic [VW-1:0] v_q;
  logic [PW-1:0] prod;

  logic          cur_only_q;
  logic [PW-1:0] pwr_lim_q;
  logic [IW-1:0] oc_lim_q;
  logic [TW-1:0] term_pwr_q;
  logic [TW-1:0] term_oc_q;

  logic          arm, gate_q, fault_q, sw_q;
  logic [1:0]    cause_q;
  logic          pwr_hit, oc_hit, short_hit, leak_hit;

  logic          cond_v [NUM_TMR];
  logic          run_v  [NUM_TMR];
  logic [TW-1:0] term_v [NUM_TMR];
  logic          exp_v  [NUM_TMR];

  // sample stage
  always_ff @(posedge clk) begin
    if (rst) begin
      i_q <= '0;
      v_q <= '0;
    end else begin
      i_q <= i_code_i;
      v_q <= v_code_i;
    end
  end

  hsw_cfg_capture #(.IW(IW), .PW(PW), .TW(TW), .MIN_DLY(MIN_DLY)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .cur_only_i (cur_only_i),
    .pwr_lim_i  (pwr_lim_i),
    .oc_lim_i   (oc_lim_i),
    .dly_pwr_i  (dly_pwr_i),
    .dly_oc_i   (dly_oc_i),
    .cur_only_q (cur_only_q),
    .pwr_lim_q  (pwr_lim_q),
    .oc_lim_q   (oc_lim_q),
    .term_pwr_q (term_pwr_q),
    .term_oc_q  (term_oc_q)
  );

  assign prod      = {{VW{1'b0}}, i_q} * {{IW{1'b0}}, v_q};
  assign pwr_hit   = !cur_only_q && (prod > pwr_lim_q);
  assign oc_hit    = i_q > oc_lim_q;
  assign short_hit = i_q > SC_CODE;
  assign leak_hit  = (i_q > LEAK_CODE) && !gate_q;

  assign cond_v[TMR_PWR]  = pwr_hit;
  assign cond_v[TMR_OC]   = oc_hit;
  assign cond_v[TMR_LEAK] = leak_hit;
  assign run_v[TMR_PWR]   = arm && !fault_q;
  assign run_v[TMR_OC]    = arm && !fault_q;
  assign run_v[TMR_LEAK]  = pwr_ok_i && !sw_q;
  assign term_v[TMR_PWR]  = term_pwr_q;
  assign term_v[TMR_OC]   = term_oc_q;
  assign term_v[TMR_LEAK] = LEAK_TERM;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    hsw_qual_timer #(.TW(TW)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .run     (run_v[g]),
      .cond    (cond_v[g]),
      .term    (term_v[g]),
      .expired (exp_v[g])
    );
  end

  hsw_fault_core u_core (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .pwr_ok_i  (pwr_ok_i),
    .short_hit (short_hit),
    .pwr_exp   (exp_v[TMR_PWR]),
    .oc_exp    (exp_v[TMR_OC]),
    .leak_exp  (exp_v[TMR_LEAK]),
    .arm       (arm),
    .gate_q    (gate_q),
    .fault_q   (fault_q),
    .sw_q      (sw_q),
    .cause_q   (cause_q)
  );

  assign gate_on_o  = gate_q;
  assign fault_n_o  = !fault_q;
  assign swfail_n_o = !sw_q;
  assign cause_o    = cause_q;
endmodule

// File: rtl/hsw_supervisor_chk.sv
`timescale 1ns/1ps
module hsw_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_i,
  input logic       pwr_ok_i,
  input logic       short_hit,
  input logic       gate_on_o,
  input logic       fault_n_o,
  input logic       swfail_n_o,
  input logic [1:0] cause_o
);
  p_gate_needs_arm_r1: assert property (@(posedge clk) disable iff (rst)
    gate_on_o |-> ($past(en_i) && $past(pwr_ok_i)));

  p_short_fast_r5: assert property (@(posedge clk) disable iff (rst)
    (en_i && pwr_ok_i && short_hit && fault_n_o) |=> (!fault_n_o && !gate_on_o));

  p_fault_kills_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !fault_n_o |-> !gate_on_o);

  p_cause_idle_r7: assert property (@(posedge clk) disable iff (rst)
    fault_n_o |-> (cause_o == 2'd0));

  p_cause_valid_r4: assert property (@(posedge clk) disable iff (rst)
    !fault_n_o |-> (cause_o != 2'd0));

  p_swfail_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (!swfail_n_o && pwr_ok_i) |=> !swfail_n_o);
endmodule

bind hsw_supervisor hsw_supervisor_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_i       (en_i),
  .pwr_ok_i   (pwr_ok_i),
  .short_hit  (short_hit),
  .gate_on_o  (gate_on_o),
  .fault_n_o  (fault_n_o),
  .swfail_n_o (swfail_n_o),
  .cause_o    (cause_o)
);

// File: tb/sim_hsw_supervisor.sv
`timescale 1ns/1ps
module sim_hsw_supervisor;
  logic        clk = 1'b0;
  logic        rst, en, pok, cur_only;
  logic [9:0]  i_c, v_c, oc_lim;
  logic [19:0] plim;
  logic [15:0] dp, doc;
  logic        gate, fault_n, swfail_n;
  logic [1:0]  cause;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int       due;
    bit       g;
    bit       fn;
    bit       sn;
    bit [1:0] c;
    string    tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hsw_supervisor u0 (
    .clk(clk), .rst(rst), .en_i(en), .pwr_ok_i(pok), .cur_only_i(cur_only),
    .i_code_i(i_c), .v_code_i(v_c), .pwr_lim_i(plim), .oc_lim_i(oc_lim),
    .dly_pwr_i(dp), .dly_oc_i(doc), .gate_on_o(gate), .fault_n_o(fault_n),
    .swfail_n_o(swfail_n), .cause_o(cause)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_at(input int d, input bit g, input bit fn, input bit sn,
                           input bit [1:0] c, input string tag);
    exp_t e;
    int   idx;
    e.due = cyc + d; e.g = g; e.fn = fn; e.sn = sn; e.c = c; e.tag = tag;
    idx = sb.size();
    for (int j = 0; j < sb.size(); j++) begin
      if (sb[j].due > e.due) begin
        idx = j;
        break;
      end
    end
    sb.insert(idx, e);
  endtask

  task automatic steady(input int n, input bit g, input bit fn, input bit sn,
                        input bit [1:0] c, input string tag);
    for (int d = 0; d < n; d++) expect_at(d, g, fn, sn, c, tag);
    tick(n);
  endtask

  // monitor: compares at the falling edge of the due cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_vec++;
      if (e.due != cyc || gate !== e.g || fault_n !== e.fn ||
          swfail_n !== e.sn || cause !== e.c) begin
        n_bad++;
        $display("FAIL %s @cyc %0d (due %0d): got gate=%b fault_n=%b swfail_n=%b cause=%0d, expected gate=%b fault_n=%b swfail_n=%b cause=%0d",
                 e.tag, cyc, e.due, gate, fault_n, swfail_n, cause, e.g, e.fn, e.sn, e.c);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all R tags): got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b0; pok = 1'b1; cur_only = 1'b0;
    i_c = '0; v_c = '0; plim = 20'd2400; oc_lim = 10'd400; dp = 16'd6; doc = 16'd3;
    tick(3);
    rst = 1'b0;
    steady(3, 0, 1, 1, 0, "R12 reset state");

    en = 1'b1;
    expect_at(0, 0, 1, 1, 0, "R1 gate before edge");
    expect_at(1, 1, 1, 1, 0, "R1 gate on");
    tick(2);

    i_c = 10'd200; v_c = 10'd12;
    steady(12, 1, 1, 1, 0, "R2 power equal to limit");
    i_c = 10'd210;
    expect_at(7, 1, 1, 1, 0, "R2 before expiry");
    expect_at(8, 0, 0, 1, 1, "R2 power trip");
    tick(8);
    i_c = '0;
    steady(6, 0, 0, 1, 1, "R7 fault held");
    en = 1'b0;
    expect_at(1, 0, 1, 1, 0, "R7 cleared by enable low, R1 gate off");
    tick(2);
    en = 1'b1;
    expect_at(1, 1, 1, 1, 0, "R7 resume");
    tick(2);

    i_c = 10'd210;
    steady(4, 1, 1, 1, 0, "R3 partial window");
    i_c = 10'd100;
    steady(1, 1, 1, 1, 0, "R3 gap");
    i_c = 10'd210;
    expect_at(7, 1, 1, 1, 0, "R3 restarted count");
    expect_at(8, 0, 0, 1, 1, "R3 trip after full window");
    tick(8);
    i_c = '0; en = 1'b0;
    tick(2);
    en = 1'b1;
    expect_at(1, 1, 1, 1, 0, "R1 re-arm");
    tick(2);

    i_c = 10'd400; v_c = 10'd1;
    steady(8, 1, 1, 1, 0, "R4 current equal to limit");
    i_c = 10'd450;
    expect_at(4, 1, 1, 1, 0, "R4 before expiry");
    expect_at(5, 0, 0, 1, 2, "R4 overcurrent trip");
    tick(5);
    i_c = '0; en = 1'b0;
    tick(2);

    doc = 16'd0;
    tick(2);
    en = 1'b1;
    expect_at(1, 1, 1, 1, 0, "R6 enable");
    tick(2);
    i_c = 10'd450;
    expect_at(3, 1, 1, 1, 0, "R6 before minimum");
    expect_at(4, 0, 0, 1, 2, "R6 zero code uses minimum delay");
    tick(4);
    i_c = '0; en = 1'b0; doc = 16'd3;
    tick(2);
    en = 1'b1;
    expect_at(1, 1, 1, 1, 0, "R1 re-arm");
    tick(2);

    i_c = 10'd950;
    expect_at(1, 1, 1, 1, 0, "R5 before");
    expect_at(2, 0, 0, 1, 3, "R5 hard short");
    tick(2);
    i_c = '0; en = 1'b0;
    tick(2);
    en = 1'b1;
    expect_at(1, 1, 1, 1, 0, "R1 re-arm");
    tick(2);

    plim = 20'd1000; oc_lim = 10'd100; dp = 16'd3; doc = 16'd3;
    i_c = 10'd150; v_c = 10'd10;
    steady(10, 1, 1, 1, 0, "R11 settings ignored while enabled");
    i_c = '0; en = 1'b0;
    tick(2);
    en = 1'b1;
    expect_at(1, 1, 1, 1, 0, "R11 enable");
    tick(2);
    i_c = 10'd150;
    expect_at(4, 1, 1, 1, 0, "R11 before expiry");
    expect_at(5, 0, 0, 1, 2, "R11 new settings, R4 current over power");
    tick(5);
    i_c = '0; en = 1'b0;
    plim = 20'd2400; oc_lim = 10'd400; dp = 16'd6; doc = 16'd3;
    tick(2);

    cur_only = 1'b1;
    tick(1);
    en = 1'b1;
    expect_at(1, 1, 1, 1, 0, "R10 enable");
    tick(2);
    i_c = 10'd210; v_c = 10'd12;
    steady(14, 1, 1, 1, 0, "R10 power path off");
    i_c = 10'd450; v_c = 10'd1;
    expect_at(4, 1, 1, 1, 0, "R10 before expiry");
    expect_at(5, 0, 0, 1, 2, "R10 overcurrent still active");
    tick(5);
    i_c = '0; en = 1'b0;
    tick(2);
    cur_only = 1'b0;
    tick(2);

    i_c = 10'd30;
    expect_at(5, 0, 1, 1, 0, "R8 before qualify");
    expect_at(6, 0, 1, 0, 0, "R8 switch failure");
    tick(6);
    i_c = '0;
    en = 1'b1;
    expect_at(1, 1, 1, 0, 0, "R9 held across enable high");
    tick(3);
    en = 1'b0;
    expect_at(1, 0, 1, 0, 0, "R9 held across enable low");
    tick(3);
    en = 1'b1;
    expect_at(1, 1, 1, 0, 0, "R9 held after toggle");
    tick(2);
    pok = 1'b0;
    expect_at(1, 0, 1, 1, 0, "R9 cleared by power cycle, R1 gate off");
    tick(2);
    pok = 1'b1;
    expect_at(1, 1, 1, 1, 0, "R1 gate after power good");
    tick(3);

    tick(2);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard (all R tags): got %0d pending, expected 0", sb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule